// File: doc/BRIEF.md
# HD Video Line-Number Inserter

This block sits in the transmit path of a high-definition serial digital video link. Each clock carries one 20-bit parallel word. The upper ten bits hold the luma channel and the lower ten bits hold the chroma channel. A one-cycle marker flags the first word (3FF) of every timing reference sequence, for both end-of-active-video (EAV) and start-of-active-video (SAV). A separate 11-bit input gives the number of the current video line.

The block counts words from each marker. It reads the H bit of the fourth word of the sequence to decide whether the sequence is an EAV. After an EAV, it overwrites the next two word slots with two formatted line-number words, and it writes the same words into both channels. Every other word passes through unchanged. The marker travels through the same fixed-latency pipeline, so later stages can stay aligned to the stream.

Finding the line number from the video format is the job of an upstream stage. The check-word computation, scrambling and serialization belong to later stages.

Top module: `hd_line_tagger`

## Requirements
- R1: While reset is held low, `vid_out` and `trs_out` read zero at every clock edge.
- R2: Every output word that is not a line-number slot equals the input word applied exactly 3 clocks earlier, with the default extra delay of one stage.
- R3: Word positions are counted from the marker word, which is index 0. When the sequence is an EAV, the words at index 4 and index 5 are replaced by the first line-number word and the second line-number word, in that order.
- R4: A sequence counts as an EAV only when bit 16 of the index-3 word is 1. Bit 16 is the H bit, bit 6 of the luma half. When bit 16 is 0, the words at index 4 and 5 pass unchanged, whatever the chroma half holds.
- R5: The first line-number word holds line[6:0] in bits 8:2 and 0 in bits 1:0. Its bit 9 is the inverse of its bit 8.
- R6: The second line-number word holds line[10:7] in bits 5:2 and 0 in bits 8:6 and 1:0. Its bit 9 is the inverse of its bit 8.
- R7: Each inserted line-number word appears identically in bits 19:10 and in bits 9:0.
- R8: The line number used is the value on `line_num` during the same clock that the index-3 word is on `vid_in`. Changes to `line_num` at any other time have no effect on that sequence.
- R9: `trs_out` equals `trs_in` delayed by the same 3 clocks as the data.
- R10: A marker that arrives before index 5 restarts the count at index 0. Slots of the abandoned sequence that have not yet been reached are not replaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vid_in | input | 20 | Input word: luma in 19:10, chroma in 9:0 |
| trs_in | input | 1 | High on the first word of each timing reference sequence |
| line_num | input | 11 | Current line number |
| vid_out | output | 20 | Output word with line numbers inserted |
| trs_out | output | 1 | Marker delayed to align with `vid_out` |

## Verification
The embedded properties assume that the marker truly flags sequence starts. They also assume that the H bit of the luma half is the only field that tells EAV from SAV, so a word with the chroma H bit set alone must never cause an insertion. The stimulus builds lines from whole EAV and SAV sequences, with arbitrary payload in between. It includes line numbers that toggle the inverted-parity bits, a line number that changes just after the index-3 word, SAV sequences whose chroma half carries a set H bit, and markers that restart a sequence early. In this way it explores the corner cases without breaking those assumptions.

// File: rtl/hdln_pkg.sv
// Package: shared types and line-number word formatting for the inserter.
// Assumes a 20-bit word, luma in the upper half, and an 11-bit line number.
package hdln_pkg;

    localparam int CHAN_W   = 10;
    localparam int LINE_W   = 11;
    localparam int POS_W    = 3;
    localparam int XYZ_IDX  = 3;
    localparam int LN0_IDX  = 4;
    localparam int LN1_IDX  = 5;
    localparam int H_BIT    = 6;

    typedef logic [CHAN_W-1:0] chan_t;

    typedef struct packed {
        chan_t luma;
        chan_t chroma;
    } hd_word_t;

    typedef enum logic [1:0] {
        SLOT_PASS = 2'd0,
        SLOT_LN0  = 2'd1,
        SLOT_LN1  = 2'd2
    } slot_e;

    // Build the first line-number word from the low seven line bits.
    function automatic chan_t fmt_ln_lo(input logic [LINE_W-1:0] ln);
        chan_t w;
        w      = '0;
        w[8:2] = ln[6:0];
        w[9]   = ~ln[6];
        return w;
    endfunction

    // Build the second line-number word from the upper four line bits.
    function automatic chan_t fmt_ln_hi(input logic [LINE_W-1:0] ln);
        chan_t w;
        w      = '0;
        w[5:2] = ln[10:7];
        w[9]   = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/hdln_trs_tracker.sv
// Tracker: counts words since the last sequence marker, latches the EAV flag
// and the line number on the index-3 word, and names the slot of the current word.
// Assumes that the marker and the word arrive in the same cycle and that the H bit
// is taken from the luma half only.
module hdln_trs_tracker
    import hdln_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mark,
    input  logic              h_bit,
    input  logic [LINE_W-1:0] line_in,
    output slot_e             slot,
    output logic [LINE_W-1:0] line_cap
);

    localparam logic [POS_W-1:0] POS_IDLE = {POS_W{1'b1}};

    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  pos_now;
    logic              eav_q;
    logic [LINE_W-1:0] ln_q;

    // Index of the present word: a marker restarts the count, which then saturates.
    always_comb begin
        if (mark)
            pos_now = '0;
        else if (pos_q == POS_IDLE)
            pos_now = POS_IDLE;
        else
            pos_now = pos_q + 1'b1;
    end

    // Hold the position, and latch the EAV flag and the line number at index 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_IDLE;
            eav_q <= 1'b0;
            ln_q  <= '0;
        end else begin
            pos_q <= pos_now;
            if (pos_now == POS_W'(XYZ_IDX)) begin
                eav_q <= h_bit;
                ln_q  <= line_in;
            end
        end
    end

    // Name the slot: the two words after the index-3 word of an EAV.
    always_comb begin
        slot = SLOT_PASS;
        if (eav_q && pos_now == POS_W'(LN0_IDX))
            slot = SLOT_LN0;
        else if (eav_q && pos_now == POS_W'(LN1_IDX))
            slot = SLOT_LN1;
    end

    assign line_cap = ln_q;

    // R3: the second line-number slot always follows the first.
    assert_ln1_after_ln0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_LN1) |-> ($past(slot) == SLOT_LN0));

    // R4: an index-3 word with H low leads to a pass-through slot next.
    assert_sav_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_now == POS_W'(XYZ_IDX) && !h_bit) |=> (slot == SLOT_PASS));

    // R10: a marker word is never treated as a line-number slot.
    assert_marker_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mark |-> (slot == SLOT_PASS));

endmodule

// File: rtl/hdln_word_merge.sv
// Merge: replaces the word in a line-number slot with the formatted words in
// both channels, and registers the word together with its marker.
// Assumes that the slot and the captured line come from the tracker in the same cycle.
module hdln_word_merge
    import hdln_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  hd_word_t          word_in,
    input  logic              mark_in,
    input  slot_e             slot,
    input  logic [LINE_W-1:0] line_cap,
    output hd_word_t          word_out,
    output logic              mark_out
);

    hd_word_t word_d;
    hd_word_t word_q;
    logic     mark_q;

    // Pick the outgoing word for this slot.
    always_comb begin
        unique case (slot)
            SLOT_LN0: word_d = '{luma: fmt_ln_lo(line_cap), chroma: fmt_ln_lo(line_cap)};
            SLOT_LN1: word_d = '{luma: fmt_ln_hi(line_cap), chroma: fmt_ln_hi(line_cap)};
            default:  word_d = word_in;
        endcase
    end

    // Register the merged word and its marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            mark_q <= 1'b0;
        end else begin
            word_q <= word_d;
            mark_q <= mark_in;
        end
    end

    assign word_out = word_q;
    assign mark_out = mark_q;

    // R7: both channels carry the same line-number word.
    assert_same_channels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != SLOT_PASS) |=> (word_q.luma == word_q.chroma));

    // R5: bit 9 of an inserted word is the inverse of bit 8.
    assert_ln_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != SLOT_PASS) |=> (word_q.luma[9] != word_q.luma[8]));

    // R6: the second word keeps bits 8:6 and 1:0 at zero.
    assert_ln_hi_zeros_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_LN1) |=> (word_q.luma[8:6] == 3'b000 && word_q.luma[1:0] == 2'b00));

    // R2: a pass-through slot leaves the word as it came in.
    assert_pass_unchanged_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_PASS) |=> (word_q == $past(word_in)));

endmodule

// File: rtl/hdln_delay_line.sv
// Delay line: a fixed-depth register chain that pads the latency of the output.
// Assumes that a depth of zero means a straight wire.
module hdln_delay_line #(
    parameter int WIDTH = 21,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [WIDTH-1:0] pipe [DEPTH];

            // Shift the chain by one stage each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= din;
                    for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
                end
            end

            assign dout = pipe[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/hd_line_tagger.sv
// Top: registers the input, tracks sequence positions, inserts line-number
// words after each EAV, and pads the output to a fixed latency of 2 + EXTRA_DELAY.
// Assumes one word per clock and a marker on the first word of each sequence.
module hd_line_tagger
    import hdln_pkg::*;
#(
    parameter int EXTRA_DELAY = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [19:0] vid_in,
    input  logic        trs_in,
    input  logic [10:0] line_num,
    output logic [19:0] vid_out,
    output logic        trs_out
);

    localparam int LATENCY = 2 + EXTRA_DELAY;
    localparam int BUS_W   = 2 * CHAN_W + 1;

    hd_word_t          s1_word;
    logic              s1_mark;
    logic [LINE_W-1:0] s1_line;
    slot_e             slot;
    logic [LINE_W-1:0] line_cap;
    hd_word_t          m_word;
    logic              m_mark;
    logic [BUS_W-1:0]  tail;

    // Capture the input word, marker and line number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_word <= '0;
            s1_mark <= 1'b0;
            s1_line <= '0;
        end else begin
            s1_word <= vid_in;
            s1_mark <= trs_in;
            s1_line <= line_num;
        end
    end

    hdln_trs_tracker u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .mark     (s1_mark),
        .h_bit    (s1_word.luma[H_BIT]),
        .line_in  (s1_line),
        .slot     (slot),
        .line_cap (line_cap)
    );

    hdln_word_merge u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_in  (s1_word),
        .mark_in  (s1_mark),
        .slot     (slot),
        .line_cap (line_cap),
        .word_out (m_word),
        .mark_out (m_mark)
    );

    hdln_delay_line #(.WIDTH(BUS_W), .DEPTH(EXTRA_DELAY)) u_pad (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({m_mark, m_word}),
        .dout  (tail)
    );

    assign trs_out = tail[BUS_W-1];
    assign vid_out = tail[BUS_W-2:0];

    // R1: the outputs are cleared one clock into reset.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (vid_out == '0 && trs_out == 1'b0));

    initial begin
        assert_latency_sane_R2: assert (LATENCY >= 2);
    end

endmodule

// File: tb/hd_line_tagger_test.sv
module hd_line_tagger_test;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] vid_in = '0;
    logic        trs_in = 1'b0;
    logic [10:0] line_num = '0;
    logic [19:0] vid_out;
    logic        trs_out;

    int n_vec = 0;
    int n_bad = 0;

    logic [19:0] exp_w [$];
    logic        exp_m [$];
    string       exp_t [$];

    int          m_idx = 99;
    bit          m_eav = 1'b0;
    int          m_line = 0;
    string       scen = "";

    always #2.5 clk = ~clk;

    hd_line_tagger uut (
        .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .trs_in(trs_in),
        .line_num(line_num), .vid_out(vid_out), .trs_out(trs_out)
    );

    function automatic int ln_first(input int l);
        int v;
        v = (l % 128) * 4;
        if (((l / 64) % 2) == 0) v = v + 512;
        return v;
    endfunction

    function automatic int ln_second(input int l);
        return ((l / 128) % 16) * 4 + 512;
    endfunction

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        report();
    end

    // Sample the outputs, then apply one word and record its expected output.
    task automatic put(input logic [19:0] w, input logic m, input int l);
        logic [19:0] ew;
        string tag;
        @(negedge clk);
        if (exp_w.size() == LAT) begin
            logic [19:0] xw;
            logic xm;
            string xt;
            xw = exp_w.pop_front();
            xm = exp_m.pop_front();
            xt = exp_t.pop_front();
            n_vec++;
            if (vid_out !== xw) begin
                n_bad++;
                $display("FAIL %s word: actual=%h expected=%h", xt, vid_out, xw);
            end
            if (trs_out !== xm) begin
                n_bad++;
                $display("FAIL R9 marker: actual=%b expected=%b", trs_out, xm);
            end
        end
        if (m) m_idx = 0;
        else if (m_idx < 99) m_idx++;
        if (m_idx == 3) begin
            m_eav = w[16];
            m_line = l;
        end
        ew = w;
        tag = {"R2 ", scen};
        if (m_idx == 4 || m_idx == 5) begin
            if (m_eav) begin
                int v;
                v = (m_idx == 4) ? ln_first(m_line) : ln_second(m_line);
                ew = {v[9:0], v[9:0]};
                tag = (m_idx == 4) ? {"R3 R5 R7 R8 ", scen} : {"R3 R6 R7 R8 ", scen};
            end else begin
                tag = {"R4 ", scen};
            end
        end
        exp_w.push_back(ew);
        exp_m.push_back(m);
        exp_t.push_back(tag);
        vid_in = w;
        trs_in = m;
        line_num = l[10:0];
    endtask

    function automatic logic [19:0] rnd20();
        return 20'($urandom);
    endfunction

    // Emit a four-word timing sequence; the luma H bit picks EAV, the chroma H bit is a decoy.
    task automatic send_trs(input bit h_luma, input bit h_chroma, input int l);
        logic [9:0] yz;
        logic [9:0] cz;
        put(20'hFFFFF, 1'b1, l);
        put(20'h00000, 1'b0, l);
        put(20'h00000, 1'b0, l);
        yz = 10'h200 | (10'(h_luma) << 6) | 10'(($urandom % 4) << 4);
        cz = 10'h200 | (10'(h_chroma) << 6);
        put({yz, cz}, 1'b0, l);
    endtask

    task automatic send_line(input int l, input bit decoy);
        send_trs(1'b1, 1'b1, l);
        for (int i = 0; i < 10; i++) put(rnd20(), 1'b0, l);
        send_trs(1'b0, decoy, l);
        for (int i = 0; i < 16; i++) put(rnd20(), 1'b0, l);
    endtask

    initial begin
        // R1: outputs read zero while reset is held.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            vid_in = rnd20();
            trs_in = 1'b1;
            n_vec++;
            if (i > 0 && (vid_out !== 20'h0 || trs_out !== 1'b0)) begin
                n_bad++;
                $display("FAIL R1 reset: actual=%h/%b expected=00000/0", vid_out, trs_out);
            end
        end
        @(negedge clk);
        vid_in = '0;
        trs_in = 1'b0;
        rst_n = 1'b1;

        // R3 R5 R6 R7: line numbers with each parity case and the extremes.
        scen = "base";
        send_line(0, 1'b0);
        send_line(1, 1'b0);
        send_line(64, 1'b1);
        send_line(2047, 1'b0);
        send_line(1125, 1'b1);
        for (int k = 0; k < 6; k++) send_line(int'($urandom % 2048), 1'b1);

        // R8: line number changes right after the index-3 word.
        scen = "R8";
        send_trs(1'b1, 1'b0, 300);
        put(rnd20(), 1'b0, 1777);
        put(rnd20(), 1'b0, 5);
        for (int i = 0; i < 6; i++) put(rnd20(), 1'b0, 5);

        // R4: SAV with decoy chroma H bit is not touched.
        scen = "R4";
        send_trs(1'b0, 1'b1, 999);
        for (int i = 0; i < 6; i++) put(rnd20(), 1'b0, 999);

        // R10: a marker at index 4 cancels the pending slots and restarts.
        scen = "R10";
        send_trs(1'b1, 1'b0, 77);
        send_trs(1'b0, 1'b0, 78);
        for (int i = 0; i < 4; i++) put(rnd20(), 1'b0, 78);
        // R10: a marker at index 2 restarts into a new EAV.
        put(20'hFFFFF, 1'b1, 10);
        put(20'h00000, 1'b0, 10);
        send_trs(1'b1, 1'b0, 1500);
        for (int i = 0; i < 6; i++) put(rnd20(), 1'b0, 1500);

        scen = "drain";
        for (int i = 0; i < LAT + 2; i++) put(20'h0, 1'b0, 0);
        report();
    end

endmodule